// File: doc/BRIEF.md
# Clock Source Mode Controller

This block turns a set of clock-control register fields into one clock-generation mode. It also drives the enables for the frequency-locked loop (FLL) and the phase-locked loop (PLL), and it gates the internal-reference and PLL clocks. It reports the active source in a two-bit status field and keeps a lock status bit and a sticky loss-of-lock flag.

Around a stop sequence it decides which clocks keep running while stopped. It also decides whether PLL-engaged operation may resume on exit. If it may not, it falls back to PLL-bypassed-external operation and emits a pulse that tells the register file to load the clock-select field with 10.

The oscillators, the FLL and the PLL are outside the block. The block only sees them as enables and a lock input.

Top module: `clkmode_ctrl`

## Requirements
- R1: The request fields decode to these modes; any other combination is invalid:
  - clock-select 00, PLL-select 0, low-power 0 gives FLL-engaged.
  - clock-select 01, internal-select 1, PLL-select 0, low-power 0 gives internal-bypassed.
  - clock-select 10, internal-select 0, PLL-select 0, low-power 0 gives external-bypassed.
  - clock-select 00, internal-select 0, PLL-select 1, low-power 0 gives PLL-engaged.
  - clock-select 10, internal-select 0, PLL-select 1, low-power 0 gives PLL-bypassed-external.
  - clock-select 01, internal-select 1, PLL-select 0, low-power 1 gives low-power-internal.
  - clock-select 10, internal-select 0, low-power 1 gives low-power-external.
  
  The mode changes on the first clock edge that sees the request. `clk_mode_st` follows one edge later and reads 00 for FLL, 01 for the internal reference, 10 for the external reference and 11 for the PLL.
- R2: In PLL-bypassed-external mode `fll_en` is 0 and `pll_en` is 1. The same holds in PLL-engaged mode.
- R3: In both low-power modes `fll_en` and `pll_en` are 0, even with `pll_clk_en` at 1. In the other run modes `pll_en` is 1 whenever `pll_clk_en` is 1.
- R4: A request for PLL-engaged mode takes effect only on an edge where `pll_lock` is 1. Until then the mode and `clk_mode_st` keep their previous values.
- R5: An invalid request leaves the mode and every output unchanged. `bad_req` is 1 for the single cycle after the first invalid cycle of a run of invalid cycles.
- R6: While stopped, `fll_en` is 0.
  - `pll_en` stays 1 only in normal stop (`stop_kind` 00) with `pll_stop_en` at 1, sampled at entry.
  - `irc_gate` is 1 only in normal stop with both `irc_en` and `irc_stop_en` at 1.
  - Any non-zero `stop_kind` is a low-power stop.
- R7: If the block enters a low-power stop from PLL-engaged mode, the exit pulse does three things: it forces PLL-bypassed-external mode, it raises `sel_force` for one cycle, and it leaves `lock_st` at 0. `clk_mode_st` reads 10 the cycle after that, and `lol_flag` is not set.
- R8: If the block enters normal stop from PLL-engaged mode with `pll_stop_en` at 0, the exit behaves as in R7.
- R9: If the block enters normal stop from PLL-engaged mode with `pll_stop_en` at 1, exit keeps PLL-engaged mode (status 11). There is no `sel_force`, and `lock_st` stays 1 while `pll_lock` stays 1.
- R10: `lock_st` equals `pll_en` AND `pll_lock`, registered one edge. `pll_gate` is `pll_en` AND `lock_st`.
- R11: `lol_flag` sets when `lock_st` is 1, `pll_en` is 1 and `pll_lock` is 0 outside a stop. It stays set until `lol_clr` is 1, and setting wins over clearing.
- R12: After synchronous reset:
  - the mode is FLL-engaged with `clk_mode_st` 00 and `fll_en` 1;
  - `lock_st`, `lol_flag`, `sel_force` and `bad_req` are 0;
  - there is no stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Clock-select request field |
| iref_sel | input | 1 | Internal-reference select |
| pll_sel | input | 1 | PLL select |
| lp_req | input | 1 | Low-power request |
| pll_clk_en | input | 1 | Keep PLL on outside low-power modes |
| pll_stop_en | input | 1 | Keep PLL running in normal stop |
| irc_en | input | 1 | Internal-reference clock enable |
| irc_stop_en | input | 1 | Keep internal reference in normal stop |
| pll_lock | input | 1 | Lock indication from the PLL |
| stop_enter | input | 1 | Stop entry strobe |
| stop_leave | input | 1 | Stop exit strobe |
| stop_kind | input | 2 | Stop type, 00 normal, non-zero low-power |
| lol_clr | input | 1 | Write-one-to-clear for loss-of-lock |
| clk_mode_st | output | 2 | Active clock source status |
| lock_st | output | 1 | Lock status |
| lol_flag | output | 1 | Sticky loss-of-lock flag |
| fll_en | output | 1 | FLL enable |
| pll_en | output | 1 | PLL enable |
| irc_gate | output | 1 | Internal-reference clock gate |
| pll_gate | output | 1 | PLL output clock gate |
| sel_force | output | 1 | Pulse: load clock-select with 10 |
| bad_req | output | 1 | Invalid request pulse |

## Verification
The enables and gates are combinational from the mode register, so they settle one edge after a request. The status field is due two edges after a request, and `lock_st`, `lol_flag`, `bad_req` and `sel_force` each one edge after their cause. Directed checks read outputs 1 ns after the edge where each result is due, counting those registers. A behavioural model in the bench advances on every rising edge, and all outputs are compared with it at each falling edge. Inputs change only 1 ns after a rising edge.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int SEL_W  = 2;
    localparam int STAT_W = 2;
    localparam int KIND_W = 2;

    localparam logic [STAT_W-1:0] ST_FLL = 2'b00;
    localparam logic [STAT_W-1:0] ST_INT = 2'b01;
    localparam logic [STAT_W-1:0] ST_EXT = 2'b10;
    localparam logic [STAT_W-1:0] ST_PLL = 2'b11;

    typedef enum logic [2:0] {
        M_FLL_ENG = 3'd0,
        M_INT_BYP = 3'd1,
        M_EXT_BYP = 3'd2,
        M_PLL_BYP = 3'd3,
        M_PLL_ENG = 3'd4,
        M_LP_INT  = 3'd5,
        M_LP_EXT  = 3'd6
    } mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             iref;
        logic             pllsel;
        logic             lp;
    } req_t;

    typedef struct packed {
        logic  ok;
        mode_e mode;
    } dec_t;

    function automatic dec_t decode(req_t r);
        dec_t d;
        d.ok   = 1'b1;
        d.mode = M_FLL_ENG;
        case (r.sel)
            2'b00: begin
                if (r.lp) d.ok = 1'b0;
                else if (r.pllsel) begin
                    if (r.iref) d.ok = 1'b0;
                    else        d.mode = M_PLL_ENG;
                end else d.mode = M_FLL_ENG;
            end
            2'b01: begin
                if (!r.iref || r.pllsel) d.ok = 1'b0;
                else d.mode = r.lp ? M_LP_INT : M_INT_BYP;
            end
            2'b10: begin
                if (r.iref)      d.ok = 1'b0;
                else if (r.lp)   d.mode = M_LP_EXT;
                else             d.mode = r.pllsel ? M_PLL_BYP : M_EXT_BYP;
            end
            default: d.ok = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [STAT_W-1:0] status_code(mode_e m);
        case (m)
            M_FLL_ENG:          return ST_FLL;
            M_INT_BYP, M_LP_INT: return ST_INT;
            M_PLL_ENG:          return ST_PLL;
            default:            return ST_EXT;
        endcase
    endfunction

    function automatic logic is_lowpwr(mode_e m);
        return (m == M_LP_INT) || (m == M_LP_EXT);
    endfunction

    function automatic logic needs_pll(mode_e m);
        return (m == M_PLL_BYP) || (m == M_PLL_ENG);
    endfunction

    function automatic logic uses_fll(mode_e m);
        return (m == M_FLL_ENG) || (m == M_INT_BYP) || (m == M_EXT_BYP);
    endfunction

    function automatic logic uses_irc(mode_e m);
        return (m == M_INT_BYP) || (m == M_LP_INT);
    endfunction

endpackage

// File: rtl/clkmode_seq.sv
module clkmode_seq
    import clkmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic              pll_lock,
    input  logic              pll_stop_en,
    input  logic              stop_enter,
    input  logic              stop_leave,
    input  logic [KIND_W-1:0] stop_kind,
    output mode_e             mode_q,
    output logic              stop_q,
    output logic              deep_q,
    output logic              psten_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              sel_force,
    output logic              bad_req
);

    dec_t dec;
    logic inv_q;
    logic from_pll_q;
    logic fallback;

    assign dec      = decode(req);
    assign fallback = from_pll_q && (deep_q || !psten_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= M_FLL_ENG;
            stop_q     <= 1'b0;
            deep_q     <= 1'b0;
            psten_q    <= 1'b0;
            from_pll_q <= 1'b0;
            stat_q     <= ST_FLL;
            sel_force  <= 1'b0;
            bad_req    <= 1'b0;
            inv_q      <= 1'b0;
        end else begin
            stat_q    <= status_code(mode_q);
            inv_q     <= !dec.ok;
            sel_force <= 1'b0;
            bad_req   <= 1'b0;
            if (!stop_q) begin
                if (stop_enter) begin
                    stop_q     <= 1'b1;
                    deep_q     <= |stop_kind;
                    psten_q    <= pll_stop_en;
                    from_pll_q <= (mode_q == M_PLL_ENG);
                end else if (!dec.ok) begin
                    bad_req <= !inv_q;
                end else if (dec.mode != M_PLL_ENG || pll_lock) begin
                    mode_q <= dec.mode;
                end
            end else if (stop_leave) begin
                stop_q <= 1'b0;
                if (fallback) begin
                    mode_q    <= M_PLL_BYP;
                    sel_force <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/clkmode_gate.sv
module clkmode_gate
    import clkmode_pkg::*;
(
    input  mode_e mode,
    input  logic  stop_q,
    input  logic  deep_q,
    input  logic  psten_q,
    input  logic  pll_clk_en,
    input  logic  irc_en,
    input  logic  irc_stop_en,
    input  logic  lock_st,
    output logic  fll_en,
    output logic  pll_en,
    output logic  irc_gate,
    output logic  pll_gate
);

    logic run_pll;

    always_comb begin
        run_pll = needs_pll(mode) || (pll_clk_en && !is_lowpwr(mode));
        if (stop_q) begin
            fll_en   = 1'b0;
            pll_en   = !deep_q && psten_q && run_pll;
            irc_gate = !deep_q && irc_en && irc_stop_en;
        end else begin
            fll_en   = uses_fll(mode);
            pll_en   = run_pll;
            irc_gate = irc_en || uses_irc(mode);
        end
        pll_gate = pll_en && lock_st;
    end

endmodule

// File: rtl/clkmode_lock.sv
module clkmode_lock (
    input  logic clk,
    input  logic rst,
    input  logic stop_q,
    input  logic pll_en,
    input  logic pll_lock,
    input  logic lol_clr,
    output logic lock_st,
    output logic lol_flag
);

    logic lock_fell;

    assign lock_fell = !stop_q && lock_st && pll_en && !pll_lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_st  <= 1'b0;
            lol_flag <= 1'b0;
        end else begin
            lock_st <= pll_en && pll_lock;
            if (lock_fell)    lol_flag <= 1'b1;
            else if (lol_clr) lol_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              iref_sel,
    input  logic              pll_sel,
    input  logic              lp_req,
    input  logic              pll_clk_en,
    input  logic              pll_stop_en,
    input  logic              irc_en,
    input  logic              irc_stop_en,
    input  logic              pll_lock,
    input  logic              stop_enter,
    input  logic              stop_leave,
    input  logic [KIND_W-1:0] stop_kind,
    input  logic              lol_clr,
    output logic [STAT_W-1:0] clk_mode_st,
    output logic              lock_st,
    output logic              lol_flag,
    output logic              fll_en,
    output logic              pll_en,
    output logic              irc_gate,
    output logic              pll_gate,
    output logic              sel_force,
    output logic              bad_req
);

    req_t  req;
    mode_e mode_q;
    logic  stop_q;
    logic  deep_q;
    logic  psten_q;

    assign req.sel    = clk_sel;
    assign req.iref   = iref_sel;
    assign req.pllsel = pll_sel;
    assign req.lp     = lp_req;

    clkmode_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .pll_lock    (pll_lock),
        .pll_stop_en (pll_stop_en),
        .stop_enter  (stop_enter),
        .stop_leave  (stop_leave),
        .stop_kind   (stop_kind),
        .mode_q      (mode_q),
        .stop_q      (stop_q),
        .deep_q      (deep_q),
        .psten_q     (psten_q),
        .stat_q      (clk_mode_st),
        .sel_force   (sel_force),
        .bad_req     (bad_req)
    );

    clkmode_gate u_gate (
        .mode        (mode_q),
        .stop_q      (stop_q),
        .deep_q      (deep_q),
        .psten_q     (psten_q),
        .pll_clk_en  (pll_clk_en),
        .irc_en      (irc_en),
        .irc_stop_en (irc_stop_en),
        .lock_st     (lock_st),
        .fll_en      (fll_en),
        .pll_en      (pll_en),
        .irc_gate    (irc_gate),
        .pll_gate    (pll_gate)
    );

    clkmode_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .stop_q   (stop_q),
        .pll_en   (pll_en),
        .pll_lock (pll_lock),
        .lol_clr  (lol_clr),
        .lock_st  (lock_st),
        .lol_flag (lol_flag)
    );

endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk
    import clkmode_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input mode_e             mode_q,
    input logic              stop_q,
    input logic              pll_lock,
    input logic              lol_clr,
    input logic              lock_st,
    input logic              lol_flag,
    input logic              sel_force,
    input logic              bad_req,
    input logic [STAT_W-1:0] clk_mode_st,
    input logic              pll_en,
    input logic              fll_en
);

    // R3: low-power modes keep both loops off
    a_r3_lowpwr_loops_off: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_LP_INT || mode_q == M_LP_EXT) |-> (!pll_en && !fll_en));

    // R4: PLL-engaged entry only after lock was seen
    a_r4_engage_needs_lock: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_PLL_ENG && $past(mode_q) != M_PLL_ENG) |-> $past(pll_lock));

    // R5: invalid indication is a single-cycle pulse
    a_r5_bad_single: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> !bad_req);

    // R6: FLL is off whenever stopped
    a_r6_stop_fll_off: assert property (@(posedge clk) disable iff (rst)
        stop_q |-> !fll_en);

    // R7: forced fallback reports external source next cycle, lock cleared
    a_r7_force_status: assert property (@(posedge clk) disable iff (rst)
        sel_force |=> (clk_mode_st == ST_EXT));

    a_r7_force_no_lock: assert property (@(posedge clk) disable iff (rst)
        sel_force |-> !lock_st);

    // R10: lock status only after a high lock input
    a_r10_lock_source: assert property (@(posedge clk) disable iff (rst)
        lock_st |-> $past(pll_lock));

    // R11: loss-of-lock is sticky until cleared
    a_r11_lol_sticky: assert property (@(posedge clk) disable iff (rst)
        (lol_flag && !lol_clr) |=> lol_flag);

endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_q      (mode_q),
    .stop_q      (stop_q),
    .pll_lock    (pll_lock),
    .lol_clr     (lol_clr),
    .lock_st     (lock_st),
    .lol_flag    (lol_flag),
    .sel_force   (sel_force),
    .bad_req     (bad_req),
    .clk_mode_st (clk_mode_st),
    .pll_en      (pll_en),
    .fll_en      (fll_en)
);

// File: tb/clkmode_ctrl_test.sv
`timescale 1ns/1ps
module clkmode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] clk_sel = 2'b00;
    logic       iref_sel = 1'b1, pll_sel = 1'b0, lp_req = 1'b0;
    logic       pll_clk_en = 1'b0, pll_stop_en = 1'b0;
    logic       irc_en = 1'b0, irc_stop_en = 1'b0, pll_lock = 1'b0;
    logic       stop_enter = 1'b0, stop_leave = 1'b0, lol_clr = 1'b0;
    logic [1:0] stop_kind = 2'b00;
    logic [1:0] clk_mode_st;
    logic       lock_st, lol_flag, fll_en, pll_en, irc_gate, pll_gate, sel_force, bad_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clkmode_ctrl uut (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .iref_sel(iref_sel),
        .pll_sel(pll_sel), .lp_req(lp_req), .pll_clk_en(pll_clk_en),
        .pll_stop_en(pll_stop_en), .irc_en(irc_en), .irc_stop_en(irc_stop_en),
        .pll_lock(pll_lock), .stop_enter(stop_enter), .stop_leave(stop_leave),
        .stop_kind(stop_kind), .lol_clr(lol_clr), .clk_mode_st(clk_mode_st),
        .lock_st(lock_st), .lol_flag(lol_flag), .fll_en(fll_en), .pll_en(pll_en),
        .irc_gate(irc_gate), .pll_gate(pll_gate), .sel_force(sel_force),
        .bad_req(bad_req)
    );

    // ---------------- reference model ----------------
    // mode numbers: 0 fll-eng, 1 int-byp, 2 ext-byp, 3 pll-byp, 4 pll-eng, 5 lp-int, 6 lp-ext
    int m_mode = 0, m_stat = 0;
    bit m_stop = 0, m_deep = 0, m_psten = 0, m_frompll = 0;
    bit m_lock = 0, m_lol = 0, m_invq = 0, m_bad = 0, m_force = 0;

    function automatic int ref_mode();
        if (clk_sel == 2'b11) return -1;
        if (clk_sel == 2'b01) return (iref_sel && !pll_sel) ? (lp_req ? 5 : 1) : -1;
        if (clk_sel == 2'b10) return iref_sel ? -1 : (lp_req ? 6 : (pll_sel ? 3 : 2));
        if (lp_req) return -1;
        if (!pll_sel) return 0;
        return iref_sel ? -1 : 4;
    endfunction

    function automatic int ref_stat(int m);
        if (m == 0) return 0;
        if (m == 1 || m == 5) return 1;
        if (m == 4) return 3;
        return 2;
    endfunction

    function automatic bit ref_pll();
        bit run;
        run = (m_mode == 3 || m_mode == 4) || (pll_clk_en && m_mode != 5 && m_mode != 6);
        if (m_stop) return !m_deep && m_psten && run;
        return run;
    endfunction

    function automatic bit ref_fll();
        return !m_stop && (m_mode <= 2);
    endfunction

    function automatic bit ref_irc();
        if (m_stop) return !m_deep && irc_en && irc_stop_en;
        return irc_en || m_mode == 1 || m_mode == 5;
    endfunction

    always @(posedge clk) begin : model
        bit pe;
        int req;
        if (rst) begin
            m_mode = 0; m_stat = 0; m_stop = 0; m_deep = 0; m_psten = 0;
            m_frompll = 0; m_lock = 0; m_lol = 0; m_invq = 0; m_bad = 0; m_force = 0;
        end else begin
            pe  = ref_pll();
            req = ref_mode();
            if (!m_stop && m_lock && pe && !pll_lock) m_lol = 1;
            else if (lol_clr) m_lol = 0;
            m_lock  = pe && pll_lock;
            m_stat  = ref_stat(m_mode);
            m_bad   = 0;
            m_force = 0;
            if (!m_stop) begin
                if (stop_enter) begin
                    m_stop = 1; m_deep = (stop_kind != 0);
                    m_psten = pll_stop_en; m_frompll = (m_mode == 4);
                end else if (req < 0) begin
                    m_bad = !m_invq;
                end else if (req != 4 || pll_lock) begin
                    m_mode = req;
                end
            end else if (stop_leave) begin
                m_stop = 0;
                if (m_frompll && (m_deep || !m_psten)) begin
                    m_mode = 3; m_force = 1;
                end
            end
            m_invq = (req < 0);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1",  "model status",   clk_mode_st, m_stat);
            chk("R10", "model lock",     lock_st,     m_lock);
            chk("R11", "model lol",      lol_flag,    m_lol);
            chk("R2",  "model fll_en",   fll_en,      ref_fll());
            chk("R3",  "model pll_en",   pll_en,      ref_pll());
            chk("R6",  "model irc_gate", irc_gate,    ref_irc());
            chk("R10", "model pll_gate", pll_gate,    ref_pll() && m_lock);
            chk("R7",  "model sel_force", sel_force,  m_force);
            chk("R5",  "model bad_req",  bad_req,     m_bad);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        // R12 reset state
        chk("R12", "status", clk_mode_st, 0);
        chk("R12", "fll_en", fll_en, 1);
        chk("R12", "lock_st", lock_st, 0);
        chk("R12", "lol", lol_flag, 0);
        chk("R12", "sel_force", sel_force, 0);
        chk("R12", "bad_req", bad_req, 0);
        rst = 1'b0;
        tick(1);

        // R1 internal-bypassed, status lags one edge
        clk_sel = 2'b01; iref_sel = 1'b1;
        tick(1);
        chk("R1", "irc_gate int mode", irc_gate, 1);
        chk("R1", "status not yet", clk_mode_st, 0);
        tick(1);
        chk("R1", "status internal", clk_mode_st, 1);

        // R1 external-bypassed
        clk_sel = 2'b10; iref_sel = 1'b0;
        tick(2);
        chk("R1", "status external", clk_mode_st, 2);
        chk("R1", "irc_gate off", irc_gate, 0);

        // R2 PLL-bypassed-external
        pll_sel = 1'b1;
        tick(2);
        chk("R2", "fll_en", fll_en, 0);
        chk("R2", "pll_en", pll_en, 1);
        chk("R2", "status", clk_mode_st, 2);

        // R10 lock tracking
        pll_lock = 1'b1;
        tick(1);
        chk("R10", "lock_st", lock_st, 1);
        chk("R10", "pll_gate", pll_gate, 1);

        // R11 loss of lock sticky and clear
        pll_lock = 1'b0;
        tick(1);
        chk("R11", "lol set", lol_flag, 1);
        chk("R10", "lock dropped", lock_st, 0);
        tick(1);
        chk("R11", "lol held", lol_flag, 1);
        lol_clr = 1'b1;
        tick(1);
        chk("R11", "lol cleared", lol_flag, 0);
        lol_clr = 1'b0;

        // R4 engage waits for lock
        clk_sel = 2'b00;
        tick(3);
        chk("R4", "status held", clk_mode_st, 2);
        pll_lock = 1'b1;
        tick(1);
        chk("R4", "status one edge later", clk_mode_st, 2);
        tick(1);
        chk("R4", "status pll", clk_mode_st, 3);

        // R6 / R9 normal stop keeping the PLL
        irc_en = 1'b1; irc_stop_en = 1'b1; pll_stop_en = 1'b1; stop_kind = 2'b00;
        stop_enter = 1'b1;
        tick(1);
        stop_enter = 1'b0;
        chk("R6", "fll off in stop", fll_en, 0);
        chk("R6", "pll kept in stop", pll_en, 1);
        chk("R6", "irc kept in stop", irc_gate, 1);
        tick(3);
        stop_leave = 1'b1;
        tick(1);
        stop_leave = 1'b0;
        chk("R9", "no force", sel_force, 0);
        tick(1);
        chk("R9", "status pll", clk_mode_st, 3);
        chk("R9", "lock kept", lock_st, 1);
        chk("R9", "no lol", lol_flag, 0);

        // R8 normal stop without PLL stop enable
        pll_stop_en = 1'b0; irc_stop_en = 1'b0;
        stop_enter = 1'b1;
        tick(1);
        stop_enter = 1'b0;
        chk("R6", "pll off in stop", pll_en, 0);
        chk("R6", "irc off in stop", irc_gate, 0);
        pll_lock = 1'b0;
        tick(3);
        stop_leave = 1'b1;
        tick(1);
        stop_leave = 1'b0;
        chk("R8", "force pulse", sel_force, 1);
        chk("R8", "lock cleared", lock_st, 0);
        clk_sel = 2'b10;
        tick(1);
        chk("R8", "status external", clk_mode_st, 2);
        chk("R8", "force ends", sel_force, 0);
        chk("R8", "no lol", lol_flag, 0);
        chk("R8", "pll_en bypass", pll_en, 1);
        pll_lock = 1'b1;
        tick(1);
        clk_sel = 2'b00;
        tick(2);
        chk("R4", "re-engaged", clk_mode_st, 3);

        // R7 low-power stop
        pll_stop_en = 1'b1; irc_stop_en = 1'b1; stop_kind = 2'b01;
        stop_enter = 1'b1;
        tick(1);
        stop_enter = 1'b0;
        chk("R6", "deep pll off", pll_en, 0);
        chk("R6", "deep irc off", irc_gate, 0);
        chk("R6", "deep fll off", fll_en, 0);
        pll_lock = 1'b0;
        tick(2);
        stop_leave = 1'b1;
        tick(1);
        stop_leave = 1'b0;
        chk("R7", "force pulse", sel_force, 1);
        chk("R7", "lock cleared", lock_st, 0);
        clk_sel = 2'b10;
        tick(1);
        chk("R7", "status external", clk_mode_st, 2);
        chk("R7", "no lol", lol_flag, 0);

        // R3 low-power modes
        lp_req = 1'b1; pll_clk_en = 1'b1; pll_lock = 1'b1;
        tick(2);
        chk("R3", "lp-ext pll_en", pll_en, 0);
        chk("R3", "lp-ext fll_en", fll_en, 0);
        chk("R3", "lp-ext status", clk_mode_st, 2);
        clk_sel = 2'b01; iref_sel = 1'b1; pll_sel = 1'b0;
        tick(2);
        chk("R3", "lp-int pll_en", pll_en, 0);
        chk("R3", "lp-int fll_en", fll_en, 0);
        chk("R3", "lp-int status", clk_mode_st, 1);

        // R5 invalid request
        clk_sel = 2'b11;
        tick(1);
        chk("R5", "bad pulse", bad_req, 1);
        chk("R5", "pll_en held", pll_en, 0);
        tick(1);
        chk("R5", "bad single", bad_req, 0);
        chk("R5", "status held", clk_mode_st, 1);
        clk_sel = 2'b01;
        tick(1);
        chk("R5", "no pulse on valid", bad_req, 0);

        // randomized phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                clk_sel  = 2'($urandom_range(0, 3));
                iref_sel = 1'($urandom_range(0, 1));
                pll_sel  = 1'($urandom_range(0, 1));
                lp_req   = ($urandom_range(0, 3) == 0);
            end
            if ($urandom_range(0, 9) == 0) pll_lock = ~pll_lock;
            if ($urandom_range(0, 9) == 0) pll_clk_en = ~pll_clk_en;
            if ($urandom_range(0, 9) == 0) pll_stop_en = ~pll_stop_en;
            if ($urandom_range(0, 9) == 0) irc_en = ~irc_en;
            if ($urandom_range(0, 9) == 0) irc_stop_en = ~irc_stop_en;
            stop_kind  = 2'($urandom_range(0, 3));
            stop_enter = ($urandom_range(0, 39) == 0);
            stop_leave = ($urandom_range(0, 9) == 0);
            lol_clr    = ($urandom_range(0, 15) == 0);
            tick(1);
        end
        stop_enter = 1'b0; stop_leave = 1'b0; lol_clr = 1'b0;
        tick(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule